// File: doc/BRIEF.md
# AC'97 Link Slot Receiver

This block receives the serial input stream of an AC'97-style codec link. It runs on the link's bit clock, which is an input, and it drives the frame sync output itself from a free-running bit counter. A frame is a 16-bit tag slot followed by twelve 20-bit data slots, 256 bit clocks in total. Frame sync is high for the whole tag slot.

The first bit sampled in each frame is the codec-ready flag. When that flag is 1, every data slot of the frame is put together msb first. Each finished slot appears on a data port with a one-cycle write strobe and its slot number, ready for an external receive FIFO. When the flag is 0, the frame's slots are still shifted in, but no write is issued. Writing resumes at the first frame whose ready flag is 1 again. The ready flag is also brought out as a status level.

Top module: `ac97_slot_rx`

## Requirements
- R1: While reset (active low) is asserted, frame sync is 1, the write strobe is 0 and the ready status is 0. The bit counter restarts at the first bit of a frame.
- R2: Frame sync is 1 for 16 consecutive bit clocks and 0 for the next 240. This repeats every 256 bit clocks, and the first frame starts when reset is released.
- R3: The serial input is sampled on the rising bit-clock edge that ends the first cycle with frame sync high, one bit clock after its rise. That sample becomes the ready status, which holds until the same point in the next frame.
- R4: Tag bits 1 to 15 have no effect on the ready status, the slot data or the strobes.
- R5: Data slot s (1 to 12) takes frame bits 16+20(s-1) to 35+20(s-1). The first bit received is bit 19 of the 20-bit data word.
- R6: Each data slot gives at most one write strobe, one cycle long, in the cycle after the slot's last bit is sampled. The data and the slot number (1 to 12) are valid in that same cycle.
- R7: A frame whose ready bit is 0 produces no write strobe.
- R8: Once a frame with ready 1 has been received, every slot of every following frame is written until a frame arrives whose ready bit is 0.
- R9: The write for slot 12 happens in the same cycle that frame sync rises for the next frame. The write uses the ready value of the frame that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdin | input | 1 | Serial data from the codec |
| fsync | output | 1 | Frame sync driven to the codec |
| slot_data | output | 20 | Assembled slot word |
| slot_wr | output | 1 | One-cycle write strobe for the receive FIFO |
| slot_idx | output | 4 | Slot number 1 to 12 for the current write |
| codec_ready | output | 1 | Ready flag sampled from the current frame |

## Verification
Two things happen on the same edge: the write for slot 12 is issued, and the frame counter wraps so that frame sync rises. One edge later, the next frame's ready bit is taken. To test this, the bench runs frames whose ready flags go 1→0 and 0→1. Across the boundary, slot 12 of the outgoing frame must follow the outgoing frame's flag, and the first slot of the incoming frame must follow the new flag.

// File: rtl/ac97_slot_rx_pkg.sv
package ac97_slot_rx_pkg;
  localparam int unsigned TAG_BITS_DEF  = 16;
  localparam int unsigned SLOT_BITS_DEF = 20;
  localparam int unsigned NUM_SLOTS_DEF = 12;

  function automatic int unsigned frame_len(int unsigned tag_bits, int unsigned slot_bits,
                                            int unsigned num_slots);
    return tag_bits + slot_bits * num_slots;
  endfunction
endpackage

// File: rtl/lrx_frame_timer.sv
module lrx_frame_timer
  import ac97_slot_rx_pkg::*;
#(
  parameter int unsigned TAG_BITS  = TAG_BITS_DEF,
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF,
  parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF,
  localparam int unsigned FRAME    = frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS),
  localparam int unsigned CW       = $clog2(FRAME),
  localparam int unsigned BW       = $clog2(SLOT_BITS),
  localparam int unsigned SW       = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          fsync,
  output logic          first_bit,
  output logic          in_data,
  output logic          slot_last,
  output logic [SW-1:0] slot_num
);
  localparam logic [CW-1:0] CNT_LAST  = CW'(FRAME - 1);
  localparam logic [CW-1:0] CNT_TAG   = CW'(TAG_BITS);
  localparam logic [BW-1:0] SBIT_LAST = BW'(SLOT_BITS - 1);
  localparam logic [SW-1:0] SNUM_LAST = SW'(NUM_SLOTS - 1);

  logic [CW-1:0] cnt_d;
  logic [BW-1:0] sbit, sbit_d;
  logic [SW-1:0] snum_d;

  always_comb begin
    fsync     = (cnt < CNT_TAG);
    in_data   = !fsync;
    first_bit = (cnt == '0);
    slot_last = in_data && (sbit == SBIT_LAST);
    cnt_d     = (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
    sbit_d    = '0;
    snum_d    = slot_num;
    if (in_data) begin
      sbit_d = slot_last ? '0 : sbit + 1'b1;
      if (slot_last) snum_d = (slot_num == SNUM_LAST) ? '0 : slot_num + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sbit     <= '0;
      slot_num <= '0;
    end else begin
      cnt      <= cnt_d;
      sbit     <= sbit_d;
      slot_num <= snum_d;
    end
  end
endmodule

// File: rtl/lrx_ready_tracker.sv
module lrx_ready_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic first_bit,
  input  logic sdin,
  output logic ready
);
  logic ready_d;

  always_comb begin
    ready_d = ready;
    if (first_bit) ready_d = sdin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= ready_d;
  end
endmodule

// File: rtl/lrx_slot_shifter.sv
module lrx_slot_shifter #(
  parameter int unsigned SLOT_BITS = 20,
  parameter int unsigned SW        = 4,
  parameter int unsigned IW        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdin,
  input  logic                 shift_en,
  input  logic                 slot_last,
  input  logic [SW-1:0]        slot_num,
  input  logic                 ready,
  output logic [SLOT_BITS-1:0] data,
  output logic                 wr,
  output logic [IW-1:0]        idx
);
  logic [SLOT_BITS-2:0] sh, sh_d;
  logic [SLOT_BITS-1:0] data_d;
  logic [IW-1:0]        idx_d;
  logic                 wr_d;
  logic                 load_en;

  always_comb begin
    sh_d    = {sh[SLOT_BITS-3:0], sdin};
    load_en = shift_en && slot_last;
    data_d  = {sh, sdin};
    idx_d   = IW'(slot_num) + 1'b1;
    wr_d    = load_en && ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      data <= '0;
      idx  <= '0;
      wr   <= 1'b0;
    end else begin
      wr <= wr_d;
      if (shift_en) sh <= sh_d;
      if (load_en) begin
        data <= data_d;
        idx  <= idx_d;
      end
    end
  end
endmodule

// File: rtl/ac97_slot_rx.sv
module ac97_slot_rx
  import ac97_slot_rx_pkg::*;
#(
  parameter int unsigned TAG_BITS  = TAG_BITS_DEF,
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF,
  parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF,
  localparam int unsigned FRAME    = frame_len(TAG_BITS, SLOT_BITS, NUM_SLOTS),
  localparam int unsigned CW       = $clog2(FRAME),
  localparam int unsigned SW       = $clog2(NUM_SLOTS),
  localparam int unsigned IW       = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdin,
  output logic                 fsync,
  output logic [SLOT_BITS-1:0] slot_data,
  output logic                 slot_wr,
  output logic [IW-1:0]        slot_idx,
  output logic                 codec_ready
);
  logic [CW-1:0] cnt;
  logic          first_bit;
  logic          in_data;
  logic          slot_last;
  logic [SW-1:0] slot_num;

  lrx_frame_timer #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .fsync(fsync), .first_bit(first_bit),
    .in_data(in_data), .slot_last(slot_last), .slot_num(slot_num)
  );

  lrx_ready_tracker ready_i (
    .clk(clk), .rst_n(rst_n), .first_bit(first_bit), .sdin(sdin), .ready(codec_ready)
  );

  lrx_slot_shifter #(
    .SLOT_BITS(SLOT_BITS), .SW(SW), .IW(IW)
  ) shift_i (
    .clk(clk), .rst_n(rst_n), .sdin(sdin), .shift_en(in_data), .slot_last(slot_last),
    .slot_num(slot_num), .ready(codec_ready), .data(slot_data), .wr(slot_wr), .idx(slot_idx)
  );
endmodule

// File: rtl/lrx_checker.sv
module lrx_checker #(
  parameter int unsigned TAG_BITS  = 16,
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned IW        = 4,
  parameter int unsigned CW        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fsync,
  input logic          slot_wr,
  input logic [IW-1:0] slot_idx,
  input logic          codec_ready,
  input logic          first_bit
);
  logic [CW:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_run <= '0;
    else if (fsync) hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  // R2: sync high phase lasts exactly one tag slot
  p_sync_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> hi_run == (CW+1)'(TAG_BITS));

  // R3: ready status only moves right after a frame's first bit
  p_ready_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(codec_ready) |-> $past(first_bit));

  // R6: strobe is a single-cycle pulse
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |=> !slot_wr);

  // R6: slot number within range on a write
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |-> (slot_idx >= IW'(1)) && (slot_idx <= IW'(NUM_SLOTS)));

  // R7: no write while codec not ready
  p_no_wr_unready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |-> codec_ready);

  // R9: last slot write coincides with sync rise when ready
  p_wrap_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fsync) && codec_ready) |-> (slot_wr && slot_idx == IW'(NUM_SLOTS)));
endmodule

bind ac97_slot_rx lrx_checker #(
  .TAG_BITS(TAG_BITS), .NUM_SLOTS(NUM_SLOTS), .IW(IW), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_wr(slot_wr), .slot_idx(slot_idx),
  .codec_ready(codec_ready), .first_bit(first_bit)
);

// File: tb/ac97_slot_rx_tb.sv
`timescale 1ns/1ps
module ac97_slot_rx_tb_top;
  localparam int FRAME = 256;
  localparam int NFR   = 7;

  logic        clk;
  logic        rst_n;
  logic        sdin;
  logic        fsync;
  logic [19:0] slot_data;
  logic        slot_wr;
  logic [3:0]  slot_idx;
  logic        codec_ready;

  int vectors;
  int miscompares;
  bit done;
  bit tag0 [NFR];

  ac97_slot_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sdin(sdin), .fsync(fsync), .slot_data(slot_data),
    .slot_wr(slot_wr), .slot_idx(slot_idx), .codec_ready(codec_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [19:0] word(int f, int s);
    return 20'((f * 40503 + s * 2654 + 32'h5A5A5) ^ (s << 15));
  endfunction

  function automatic logic bit_at(int t);
    int f, p, s, b;
    f = t / FRAME;
    p = t % FRAME;
    if (p == 0) return tag0[f];
    if (p < 16) return logic'(((p + f) & 1) != 0);
    s = (p - 16) / 20;
    b = (p - 16) % 20;
    return word(f, s)[19 - b];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    tag0[0] = 1; tag0[1] = 1; tag0[2] = 0; tag0[3] = 0;
    tag0[4] = 1; tag0[5] = 0; tag0[6] = 1;
    rst_n = 1'b0;
    sdin  = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fsync == 1'b1, "R1", "fsync", int'(fsync), 1);
    chk(slot_wr == 1'b0, "R1", "slot_wr", int'(slot_wr), 0);
    chk(codec_ready == 1'b0, "R1", "codec_ready", int'(codec_ready), 0);
    rst_n = 1'b1;
    for (int t = 0; t < NFR * FRAME; t++) begin
      int p, pp, ff, s;
      bit exp_wr, exp_rdy;
      p = t % FRAME;
      // R2 sync pattern
      chk(fsync == (p < 16), "R2", "fsync", int'(fsync), int'(p < 16));
      // R3/R4 ready status follows only bit 0
      exp_rdy = (t == 0) ? 1'b0 : tag0[(t - 1) / FRAME];
      chk(codec_ready == exp_rdy, "R3", "codec_ready", int'(codec_ready), int'(exp_rdy));
      exp_wr = 1'b0;
      s = 0;
      ff = 0;
      if (t > 0) begin
        pp = (t - 1) % FRAME;
        ff = (t - 1) / FRAME;
        if (pp >= 16 && ((pp - 16) % 20) == 19) begin
          s = (pp - 16) / 20;
          exp_wr = tag0[ff];
        end
      end
      // R6 R7 R8 R9 strobe schedule, gated by the frame's ready bit
      if (p == 0 && t > 0)
        chk(slot_wr == exp_wr, "R9", "slot_wr at sync rise", int'(slot_wr), int'(exp_wr));
      else
        chk(slot_wr == exp_wr, exp_wr ? "R8" : "R7", "slot_wr", int'(slot_wr), int'(exp_wr));
      if (exp_wr && slot_wr) begin
        // R5 msb-first assembly (tag bits 1..15 toggled per R4)
        chk(slot_data == word(ff, s), "R5", "slot_data", int'(slot_data), int'(word(ff, s)));
        chk(slot_idx == 4'(s + 1), "R6", "slot_idx", int'(slot_idx), s + 1);
      end
      sdin = bit_at(t);
      @(posedge clk);
      @(negedge clk);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule